// File: doc/BRIEF.md
# Log-domain to floating-point converter

The block turns a word in a logarithmic number format into a binary floating-point word with no denormal support. The log word has two flag bits, a sign bit, a two's-complement integer part and an unsigned fraction part; its value is (-1)^sign · 2^(integer.fraction). The floating-point exponent comes from the integer part plus the bias. The significand is 2^fraction, which always lies in [1,2), so it maps onto the stored fraction with an implicit leading one.

2^fraction is not read from one table with 2^l entries. The fraction is cut into K equal bit slices. Each slice addresses a small table of 2^(slice·2^-position) constants, and the K factors are multiplied in a pipelined chain with one register per multiply. A final stage rounds the product to the output width, folds a rounding carry into the exponent, clamps underflow to zero and overflow to infinity, and maps the flag states onto the special encodings. A valid bit travels with the data, and one conversion can be accepted on every cycle.

Top module: `lns2fp_conv`

## Requirements
- R1: Flag code 00 (zero) yields exponent 0 and fraction 0, whatever the integer and fraction fields hold.
- R2: Flag code 10 (infinity) yields the all-ones exponent with fraction 0.
- R3: Flag code 11 (not-a-number) yields the all-ones exponent with only the fraction MSB set.
- R4: For flag code 01 (number) with an in-range result, {exponent, fraction} lies within one unit in the last place of round-to-nearest(2^(f/2^l)) at exponent integer+BIAS (BIAS = 2^(EXP_W-1)-1 = 31).
- R5: A number with fraction field 0 converts exactly: output fraction 0 and exponent integer+31.
- R6: When the rounded significand reaches 2.0, the output fraction is 0 and the exponent is one higher (e.g. integer 0 with fraction 0xFFF gives exponent 32).
- R7: A number whose biased exponent, after any rounding carry, is 0 or below gives exponent 0 and fraction 0 (integer -32, or -31 without a carry).
- R8: A number whose biased exponent reaches 63 or more, after any rounding carry, gives infinity. Integer 31 with fraction 0 stays finite at exponent 62.
- R9: The output sign bit equals the input sign bit for every flag code.
- R10: out_valid is low after reset and rises exactly SLICES+1 = 4 cycles after in_valid. Back-to-back inputs come out in order on consecutive cycles.

Input layout (defaults): lns_in[20:19] flag, [18] sign, [17:12] integer, [11:0] fraction. Output layout: fp_out[16] sign, [15:10] exponent, [9:0] fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | lns_in holds a word to convert |
| lns_in | input | 3+INT_W+LFRAC_W | Flags, sign, integer, fraction |
| out_valid | output | 1 | fp_out holds a result |
| fp_out | output | 1+EXP_W+FRAC_W | Sign, biased exponent, fraction |

## Verification
The bench targets the rounding carry at fraction 0xFFF. A design that drops this carry returns fraction 1023 with the old exponent instead of fraction 0 with the exponent one higher. At the bottom of the range, integer -31 gives zero for an ordinary fraction but exponent 1 when the carry lifts it. A design that clamps before rounding gets one of these two cases wrong. At the top, integer 31 must stay finite at fraction 0 and become infinity when the carry occurs; a wrong comparison bound breaks one of the two. Back-to-back inputs expose a valid bit that is out of step with the multiply pipeline, which shows up as shifted or duplicated results. The bench also checks special flags carrying unrelated field values, and the sign on special results.

// File: rtl/lns2fp_pkg.sv
package lns2fp_pkg;

    typedef enum logic [1:0] {
        LF_ZERO = 2'b00,
        LF_NUM  = 2'b01,
        LF_INF  = 2'b10,
        LF_NAN  = 2'b11
    } lns_flag_e;

    // Rounded fixed-point value of 2^(val / 2^(slice_w*(pos+1))) with frac_bits fraction bits
    function automatic int exp2_fixed(input int pos, input int slice_w,
                                      input int val, input int frac_bits);
        real x;
        real y;
        x = real'(val) / (2.0 ** real'(slice_w * (pos + 1)));
        y = (2.0 ** x) * (2.0 ** real'(frac_bits));
        return $rtoi(y + 0.5);
    endfunction

endpackage

// File: rtl/lns2fp_rom.sv
module lns2fp_rom
    import lns2fp_pkg::*;
#(
    parameter int SLICE_W = 4,
    parameter int POS     = 0,
    parameter int W       = 19
) (
    input  logic [SLICE_W-1:0] idx_i,
    output logic [W-1:0]       fac_o
);
    localparam int N = 1 << SLICE_W;

    logic [W-1:0] tbl [N];

    for (genvar e = 0; e < N; e++) begin : g_ent
        localparam int VAL = exp2_fixed(POS, SLICE_W, e, W - 1);
        assign tbl[e] = W'(VAL);
    end

    assign fac_o = tbl[idx_i];

endmodule

// File: rtl/lns2fp_mul_stage.sv
module lns2fp_mul_stage #(
    parameter int W      = 19,
    parameter int K      = 3,
    parameter int IDX    = 1,
    parameter int SIDE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  logic [SIDE_W-1:0]     side_i,
    input  logic [K-1:0][W-1:0]   fac_i,
    output logic                  vld_o,
    output logic [SIDE_W-1:0]     side_o,
    output logic [K-1:0][W-1:0]   fac_o
);
    typedef struct packed {
        logic                vld;
        logic [SIDE_W-1:0]   side;
        logic [K-1:0][W-1:0] fac;
    } stg_t;

    stg_t st_d, st_q;
    logic [2*W-1:0] prod;
    logic [2*W-1:0] rnd;

    always_comb begin
        prod       = fac_i[0] * fac_i[IDX];
        rnd        = prod + ((2*W)'(1) << (W - 2));
        st_d.vld   = vld_i;
        st_d.side  = side_i;
        st_d.fac   = fac_i;
        st_d.fac[0] = rnd[2*W-2 -: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign side_o = st_q.side;
    assign fac_o  = st_q.fac;

    // R10
    vld_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    // R4
    acc_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> fac_o[0][W-1]);

endmodule

// File: rtl/lns2fp_pack.sv
module lns2fp_pack
    import lns2fp_pkg::*;
#(
    parameter int INT_W  = 6,
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 10,
    parameter int GUARD  = 8,
    parameter int W      = 1 + FRAC_W + GUARD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  lns_flag_e               flag_i,
    input  logic                    sign_i,
    input  logic signed [INT_W-1:0] int_i,
    input  logic [W-1:0]            acc_i,
    output logic                    vld_o,
    output logic [EXP_W+FRAC_W:0]   fp_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam int EB_W = ((INT_W > EXP_W) ? INT_W : EXP_W) + 2;

    typedef struct packed {
        logic              vld;
        logic              sign;
        logic [EXP_W-1:0]  ex;
        logic [FRAC_W-1:0] frac;
    } out_t;

    out_t st_d, st_q;
    logic [W:0]              sum;
    logic [FRAC_W+1:0]       mant_r;
    logic                    carry;
    logic [FRAC_W-1:0]       frac_n;
    logic signed [EB_W-1:0]  biased;

    always_comb begin
        sum    = {1'b0, acc_i} + (W+1)'(1 << (GUARD - 1));
        mant_r = sum[W:GUARD];
        carry  = mant_r[FRAC_W+1];
        frac_n = carry ? '0 : mant_r[FRAC_W-1:0];
        biased = EB_W'(int_i) + EB_W'(BIAS) + EB_W'(carry);

        st_d.vld  = vld_i;
        st_d.sign = sign_i;
        st_d.ex   = '0;
        st_d.frac = '0;
        unique case (flag_i)
            LF_ZERO: begin
                st_d.ex   = '0;
                st_d.frac = '0;
            end
            LF_INF: begin
                st_d.ex   = EXP_W'(EMAX);
                st_d.frac = '0;
            end
            LF_NAN: begin
                st_d.ex   = EXP_W'(EMAX);
                st_d.frac = FRAC_W'(1) << (FRAC_W - 1);
            end
            default: begin
                if (biased <= 0) begin
                    st_d.ex   = '0;
                    st_d.frac = '0;
                end else if (biased >= $signed(EB_W'(EMAX))) begin
                    st_d.ex   = EXP_W'(EMAX);
                    st_d.frac = '0;
                end else begin
                    st_d.ex   = biased[EXP_W-1:0];
                    st_d.frac = frac_n;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign fp_o  = {st_q.sign, st_q.ex, st_q.frac};

    // R7
    zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && fp_o[FRAC_W +: EXP_W] == '0) |-> (fp_o[FRAC_W-1:0] == '0));

    // R3
    nan_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && flag_i == LF_NAN) |=>
            (fp_o[FRAC_W +: EXP_W] == EXP_W'(EMAX) && fp_o[FRAC_W-1:0] != '0));

    // R2
    inf_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && flag_i == LF_INF) |=>
            (fp_o[FRAC_W +: EXP_W] == EXP_W'(EMAX) && fp_o[FRAC_W-1:0] == '0));

    // R9
    sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (fp_o[EXP_W+FRAC_W] == $past(sign_i)));

endmodule

// File: rtl/lns2fp_conv.sv
module lns2fp_conv
    import lns2fp_pkg::*;
#(
    parameter int INT_W   = 6,
    parameter int LFRAC_W = 12,
    parameter int SLICES  = 3,
    parameter int EXP_W   = 6,
    parameter int FRAC_W  = 10,
    parameter int GUARD   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2+INT_W+LFRAC_W:0]      lns_in,
    output logic                          out_valid,
    output logic [EXP_W+FRAC_W:0]         fp_out
);
    localparam int SLICE_W = LFRAC_W / SLICES;
    localparam int W       = 1 + FRAC_W + GUARD;
    localparam int SIDE_W  = 3 + INT_W;

    typedef struct packed {
        logic                     vld;
        logic [SIDE_W-1:0]        side;
        logic [SLICES-1:0][W-1:0] fac;
    } look_t;

    logic [LFRAC_W-1:0]       lfrac;
    logic [SLICES-1:0][W-1:0] rom_fac;
    look_t                    lk_d, lk_q;

    assign lfrac = lns_in[LFRAC_W-1:0];

    for (genvar j = 0; j < SLICES; j++) begin : g_rom
        lns2fp_rom #(
            .SLICE_W(SLICE_W),
            .POS    (j),
            .W      (W)
        ) i_rom (
            .idx_i(lfrac[LFRAC_W-1-j*SLICE_W -: SLICE_W]),
            .fac_o(rom_fac[j])
        );
    end

    always_comb begin
        lk_d.vld  = in_valid;
        lk_d.side = lns_in[2+INT_W+LFRAC_W:LFRAC_W];
        lk_d.fac  = rom_fac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    logic                     ch_vld  [SLICES];
    logic [SIDE_W-1:0]        ch_side [SLICES];
    logic [SLICES-1:0][W-1:0] ch_fac  [SLICES];

    assign ch_vld[0]  = lk_q.vld;
    assign ch_side[0] = lk_q.side;
    assign ch_fac[0]  = lk_q.fac;

    for (genvar i = 1; i < SLICES; i++) begin : g_mul
        lns2fp_mul_stage #(
            .W     (W),
            .K     (SLICES),
            .IDX   (i),
            .SIDE_W(SIDE_W)
        ) i_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (ch_vld[i-1]),
            .side_i(ch_side[i-1]),
            .fac_i (ch_fac[i-1]),
            .vld_o (ch_vld[i]),
            .side_o(ch_side[i]),
            .fac_o (ch_fac[i])
        );
    end

    logic [SIDE_W-1:0]        last_side;
    logic [SLICES-1:0][W-1:0] last_fac;
    lns_flag_e                last_flag;

    assign last_side = ch_side[SLICES-1];
    assign last_fac  = ch_fac[SLICES-1];
    assign last_flag = lns_flag_e'(last_side[SIDE_W-1 -: 2]);

    lns2fp_pack #(
        .INT_W (INT_W),
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W),
        .GUARD (GUARD),
        .W     (W)
    ) i_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (ch_vld[SLICES-1]),
        .flag_i(last_flag),
        .sign_i(last_side[INT_W]),
        .int_i ($signed(last_side[INT_W-1:0])),
        .acc_i (last_fac[0]),
        .vld_o (out_valid),
        .fp_o  (fp_out)
    );

endmodule

// File: tb/test_lns2fp_conv.sv
`timescale 1ns/1ps
module test_lns2fp_conv;

    localparam int LAT = 4;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [20:0] lns_in = '0;
    logic        out_valid;
    logic [16:0] fp_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lns2fp_conv i_lns2fp_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .lns_in   (lns_in),
        .out_valid(out_valid),
        .fp_out   (fp_out)
    );

    function automatic logic [20:0] mk(input int fl, input int sg, input int iv, input int fr);
        logic [31:0] ivb;
        ivb = 32'(iv);
        return {2'(fl), 1'(sg), ivb[5:0], 12'(fr)};
    endfunction

    localparam logic [20:0] VEC [NV] = '{
        mk(1, 0,   0, 'h000), mk(1, 0,   0, 'h800), mk(1, 1,   5, 'h123),
        mk(1, 0,  -3, 'hfff), mk(1, 0,  20, 'h555), mk(1, 1, -10, 'haaa),
        mk(1, 0,   1, 'h001), mk(1, 0,  -1, 'h7ff), mk(1, 1,  12, 'h400),
        mk(1, 0,  30, 'hc00), mk(1, 0, -30, 'h321), mk(1, 1,   7, 'hedc)
    };

    function automatic logic [16:0] model(input logic [20:0] w);
        logic              sg;
        logic signed [5:0] ip;
        int                f, q, be;
        real               r;
        sg = w[18];
        ip = $signed(w[17:12]);
        f  = int'(w[11:0]);
        case (w[20:19])
            2'b00: return {sg, 16'h0};
            2'b10: return {sg, 6'h3f, 10'h0};
            2'b11: return {sg, 6'h3f, 10'h200};
            default: begin
                r  = 2.0 ** (real'(f) / 4096.0);
                q  = $rtoi(r * 1024.0 + 0.5);
                be = int'(ip) + 31;
                if (q >= 2048) begin
                    be = be + 1;
                    q  = 1024;
                end
                if (be <= 0)  return {sg, 16'h0};
                if (be >= 63) return {sg, 6'h3f, 10'h0};
                return {sg, 6'(be), 10'(q - 1024)};
            end
        endcase
    endfunction

    task automatic cmp(input logic [16:0] act, input logic [16:0] exp_v,
                       input bit exact, input string req);
        int d;
        bit bad;
        d = int'(act[15:0]) - int'(exp_v[15:0]);
        bad = (act[16] != exp_v[16]) || (exact ? (d != 0) : (d > 1 || d < -1));
        n_chk++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp_v);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp_v, input string req);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp_v);
        end
    endtask

    task automatic run_one(input logic [20:0] w, input bit exact, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        lns_in   = w;
        @(negedge clk);
        in_valid = 1'b0;
        lns_in   = '0;
        repeat (LAT - 1) @(negedge clk);
        chk_bit(out_valid, 1'b1, req);
        cmp(fp_out, model(w), exact, req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk_bit(out_valid, 1'b0, "R10 reset valid");
        cmp(fp_out, 17'h0, 1'b1, "R10 reset data");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 table of ordinary numbers
        for (int i = 0; i < NV; i++) run_one(VEC[i], 1'b0, "R4 table");

        // R1 zero flag ignores other fields
        run_one(mk(0, 1, 17, 'habc), 1'b1, "R1 zero flag");
        // R2 infinity
        run_one(mk(2, 0, -5, 'h3c1), 1'b1, "R2 inf flag");
        // R3 NaN, R9 sign carried
        run_one(mk(3, 1, 9, 'h000), 1'b1, "R3 R9 nan flag");
        run_one(mk(2, 1, 0, 'h000), 1'b1, "R9 neg inf");
        // R5 exact at zero fraction
        run_one(mk(1, 0, 0, 'h000), 1'b1, "R5 int0");
        run_one(mk(1, 1, -7, 'h000), 1'b1, "R5 int-7");
        // R6 rounding carry into exponent
        run_one(mk(1, 0, 0, 'hfff), 1'b1, "R6 carry int0");
        run_one(mk(1, 0, -31, 'hfff), 1'b1, "R6 carry lifts from zero");
        // R7 underflow to zero
        run_one(mk(1, 0, -32, 'h000), 1'b1, "R7 min int");
        run_one(mk(1, 1, -31, 'h100), 1'b1, "R7 biased zero");
        // R8 overflow and top boundary
        run_one(mk(1, 0, 31, 'hfff), 1'b1, "R8 carry to inf");
        run_one(mk(1, 0, 31, 'h000), 1'b1, "R8 top finite");

        // R10 back-to-back stream
        @(negedge clk);
        in_valid = 1'b1; lns_in = mk(1, 0, 2, 'h000);
        @(negedge clk);
        lns_in = mk(3, 0, 0, 'h000);
        @(negedge clk);
        lns_in = mk(1, 1, -4, 'h800);
        @(negedge clk);
        in_valid = 1'b0; lns_in = '0;
        chk_bit(out_valid, 1'b0, "R10 not early");
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R10 stream 0");
        cmp(fp_out, model(mk(1, 0, 2, 'h000)), 1'b1, "R10 stream 0");
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R10 stream 1");
        cmp(fp_out, model(mk(3, 0, 0, 'h000)), 1'b1, "R10 stream 1");
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R10 stream 2");
        cmp(fp_out, model(mk(1, 1, -4, 'h800)), 1'b0, "R10 stream 2");
        @(negedge clk);
        chk_bit(out_valid, 1'b0, "R10 drain");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule